// File: doc/BRIEF.md
# Dual-Page Streaming Histogram Accumulator

This block counts how often each value range occurs in a sample stream. Every valid sample picks one bin from its top bits, and that bin's count goes up by one. Counting happens in intervals that a sync pulse on the stream marks out. There are two pages of bin storage. One page collects counts for the running interval. The other keeps the finished counts of the interval before it, so a controller can read them at leisure through a small memory read port.

On every sync pulse the two pages trade roles. The page that just finished becomes readable. The page that was readable becomes the collecting page, and its old contents must not leak into the new counts. Each bin of each page carries a "written this interval" flag. A sync clears every flag of the page that starts collecting. Any bin whose flag is clear reads as zero, both in the increment path and on the memory port.

An increment is a read-modify-write on storage with one cycle of read latency. Two valid samples in a row that land in the same bin are handled by passing the value just written straight to the next increment. Everything runs on one clock.

Top module: `stream_histogram`

## Requirements
- R1: From reset until the first sync pulse, every memory read returns zero, even while samples are being counted.
- R2: `mem_rd_valid` is high in exactly the cycle after a cycle with `mem_rd_en` high, and low at every other time. `mem_rd_data` carries the hold-page count of the requested bin in that cycle.
- R3: A valid sample is counted in the bin given by the upper `$clog2(NUM_BINS)` bits of `in_data`, read as an unsigned number. With the defaults, that is `in_data[7:4]`.
- R4: A sample with `in_valid` low changes no count.
- R5: A clock edge with `in_sync` high swaps the pages. A valid sample in that same cycle is counted in the new interval.
- R6: From the edge after the sync edge onward, a read returns the final count of the interval that the sync closed. This is well within 10 cycles.
- R7: Valid samples on consecutive cycles that hit the same bin are all counted.
- R8: A page that starts collecting begins from zero in every bin, whatever it held two intervals earlier.
- R9: Reads of the hold page are not affected by samples being counted at the same time.
- R10: `mem_wr_en` and `mem_wr_data` have no effect on any count or read result.
- R11: Bin counters are `$clog2(SAMPLES_PER_SYNC+1)` bits wide. A full interval of `SAMPLES_PER_SYNC` samples into one bin reads back as exactly that number.
- R12: A sync pulse with `in_valid` low still swaps the pages. An interval with no valid samples reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample qualifier |
| in_sync | input | 1 | Interval boundary pulse, swaps pages |
| in_data | input | DATA_W | Sample value; upper bits select the bin |
| mem_rd_en | input | 1 | Read request for the hold page |
| mem_rd_addr | input | $clog2(NUM_BINS) | Bin to read |
| mem_wr_en | input | 1 | Write request, ignored |
| mem_wr_data | input | $clog2(SAMPLES_PER_SYNC+1) | Write data, ignored |
| mem_rd_valid | output | 1 | Read data strobe, one cycle after the request |
| mem_rd_data | output | $clog2(SAMPLES_PER_SYNC+1) | Hold-page bin count |

## Verification
A read request sampled at one edge yields `mem_rd_valid` and its data after the next edge. The bench therefore checks each request at the falling edge one cycle after it drove it, and checks `mem_rd_valid` low in every cycle with no request pending. A swap takes effect at the sync edge, and the final count of the closed interval is due from the next edge on. So the bench updates its model of the hold page at the sync cycle and issues no read in that same cycle. Increments take two edges to reach storage but never show on the hold page within an interval, so the bench never samples them mid-flight; it checks them only after the next sync.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic {
    PG_A = 1'b0,
    PG_B = 1'b1
  } page_e;

  function automatic page_e other_page(input page_e p);
    return (p == PG_A) ? PG_B : PG_A;
  endfunction

endpackage

// File: rtl/hist_page_ram.sv
module hist_page_ram #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] store [DEPTH];

  // storage without reset; contents are qualified by the touch map
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // registered read, returns contents before a same-edge write
  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/hist_touch_map.sv
module hist_touch_map
  import hist_pkg::*;
#(
  parameter int unsigned NUM_BINS = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_en,
  input  page_e                    clr_page,
  input  logic                     set_en,
  input  page_e                    set_page,
  input  logic [ADDR_W-1:0]        set_addr,
  output logic [1:0][NUM_BINS-1:0] touched
);

  logic [1:0][NUM_BINS-1:0] touched_nxt;

  // set wins over clear; the two never target the same page in one cycle
  always_comb begin
    touched_nxt = touched;
    if (clr_en) begin
      touched_nxt[clr_page] = '0;
    end
    if (set_en) begin
      touched_nxt[set_page][set_addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched <= '0;
    end else begin
      touched <= touched_nxt;
    end
  end

endmodule

// File: rtl/hist_rmw_stage.sv
module hist_rmw_stage
  import hist_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_en,
  input  page_e                 smp_page,
  input  logic [ADDR_W-1:0]     smp_bin,
  input  logic [1:0][CNT_W-1:0] page_rdata,
  input  logic                  cur_known,
  output logic                  wr_en,
  output page_e                 wr_page,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [CNT_W-1:0]      wr_data
);

  // stage 1: sample waiting for its read data
  logic              s1_vld, s1_vld_nxt;
  page_e             s1_pg;
  logic [ADDR_W-1:0] s1_bin;

  // write-back record of the increment committed at the last edge
  logic              wb_vld, wb_vld_nxt;
  page_e             wb_pg;
  logic [ADDR_W-1:0] wb_bin;
  logic [CNT_W-1:0]  wb_val;

  logic              fwd_hit;
  logic [CNT_W-1:0]  stored_cnt;
  logic [CNT_W-1:0]  base_cnt;

  always_comb begin
    stored_cnt = page_rdata[s1_pg];
    fwd_hit    = wb_vld && (wb_pg == s1_pg) && (wb_bin == s1_bin);
    if (fwd_hit) begin
      base_cnt = wb_val;
    end else if (cur_known) begin
      base_cnt = stored_cnt;
    end else begin
      base_cnt = '0;
    end
    s1_vld_nxt = smp_en;
    wb_vld_nxt = s1_vld;
  end

  assign wr_en   = s1_vld;
  assign wr_page = s1_pg;
  assign wr_addr = s1_bin;
  assign wr_data = base_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_pg  <= PG_A;
      s1_bin <= '0;
    end else begin
      s1_vld <= s1_vld_nxt;
      if (smp_en) begin
        s1_pg  <= smp_page;
        s1_bin <= smp_bin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld <= 1'b0;
      wb_pg  <= PG_A;
      wb_bin <= '0;
      wb_val <= '0;
    end else begin
      wb_vld <= wb_vld_nxt;
      if (s1_vld) begin
        wb_pg  <= s1_pg;
        wb_bin <= s1_bin;
        wb_val <= wr_data;
      end
    end
  end

  // back-to-back hits on one bin must step the count by one each time
  assert_fwd_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && (wr_page == $past(wr_page)) && (wr_addr == $past(wr_addr)))
      |-> (wr_data == $past(wr_data) + CNT_W'(1)));

  // an increment never wraps to zero when an interval stays within its sample budget
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != '0));

endmodule

// File: rtl/stream_histogram.sv
module stream_histogram
  import hist_pkg::*;
#(
  parameter int unsigned DATA_W           = 8,
  parameter int unsigned NUM_BINS         = 16,
  parameter int unsigned SAMPLES_PER_SYNC = 64,
  localparam int unsigned ADDR_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int unsigned CNT_W  = $clog2(SAMPLES_PER_SYNC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [DATA_W-1:0] in_data,
  input  logic              mem_rd_en,
  input  logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_wr_en,
  input  logic [CNT_W-1:0]  mem_wr_data,
  output logic              mem_rd_valid,
  output logic [CNT_W-1:0]  mem_rd_data
);

  // page roles
  page_e acc_pg, acc_pg_nxt, hold_pg_nxt;

  // sample path
  logic [ADDR_W-1:0]        in_bin;
  logic                     wr_en;
  page_e                    wr_page;
  logic [ADDR_W-1:0]        wr_addr;
  logic [CNT_W-1:0]         wr_data;
  logic                     cur_known;
  logic [1:0][CNT_W-1:0]    page_rdata;
  logic [1:0][NUM_BINS-1:0] touched;

  // host read path
  logic  rdv_q, rdv_nxt;
  page_e rd_pg_q;
  logic  rd_known_q;

  // the write port of the memory interface is accepted and discarded
  logic unused_inputs;
  assign unused_inputs = mem_wr_en ^ (^mem_wr_data) ^ (^in_data);

  assign in_bin = in_data[DATA_W-1 -: ADDR_W];

  always_comb begin
    acc_pg_nxt  = in_sync ? other_page(acc_pg) : acc_pg;
    hold_pg_nxt = other_page(acc_pg_nxt);
    rdv_nxt     = mem_rd_en;
    cur_known   = touched[wr_page][wr_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pg <= PG_A;
    end else if (in_sync) begin
      acc_pg <= acc_pg_nxt;
    end
  end

  // one storage page per role slot; each page serves whichever role it holds
  for (genvar p = 0; p < 2; p++) begin : g_page
    logic              pg_is_acc;
    logic              pg_re;
    logic [ADDR_W-1:0] pg_raddr;
    logic              pg_we;

    assign pg_is_acc = (acc_pg_nxt == page_e'(p));
    assign pg_re     = pg_is_acc ? in_valid : mem_rd_en;
    assign pg_raddr  = pg_is_acc ? in_bin : mem_rd_addr;
    assign pg_we     = wr_en && (wr_page == page_e'(p));

    hist_page_ram #(
      .DEPTH (NUM_BINS),
      .ADDR_W(ADDR_W),
      .WORD_W(CNT_W)
    ) u_ram (
      .clk  (clk),
      .we   (pg_we),
      .waddr(wr_addr),
      .wdata(wr_data),
      .re   (pg_re),
      .raddr(pg_raddr),
      .rdata(page_rdata[p])
    );
  end

  hist_touch_map #(
    .NUM_BINS(NUM_BINS),
    .ADDR_W  (ADDR_W)
  ) u_touch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (in_sync),
    .clr_page(acc_pg_nxt),
    .set_en  (wr_en),
    .set_page(wr_page),
    .set_addr(wr_addr),
    .touched (touched)
  );

  hist_rmw_stage #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (in_valid),
    .smp_page  (acc_pg_nxt),
    .smp_bin   (in_bin),
    .page_rdata(page_rdata),
    .cur_known (cur_known),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q      <= 1'b0;
      rd_pg_q    <= PG_B;
      rd_known_q <= 1'b0;
    end else begin
      rdv_q <= rdv_nxt;
      if (mem_rd_en) begin
        rd_pg_q    <= hold_pg_nxt;
        rd_known_q <= touched[hold_pg_nxt][mem_rd_addr];
      end
    end
  end

  assign mem_rd_valid = rdv_q;
  assign mem_rd_data  = rd_known_q ? page_rdata[rd_pg_q] : '0;

  assert_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_rd_valid);

  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> !mem_rd_valid);

  assert_fresh_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |=> (touched[acc_pg] == '0));

  assert_hold_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_page == acc_pg));

endmodule

// File: tb/tb_stream_histogram.sv
module tb_stream_histogram;

  localparam int DATA_W = 8;
  localparam int NB     = 16;
  localparam int SPS    = 64;
  localparam int AW     = $clog2(NB);
  localparam int CW     = $clog2(SPS + 1);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_sync;
  logic [DATA_W-1:0] in_data;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_wr_en;
  logic [CW-1:0] mem_wr_data;
  logic          mem_rd_valid;
  logic [CW-1:0] mem_rd_data;

  stream_histogram #(
    .DATA_W(DATA_W),
    .NUM_BINS(NB),
    .SAMPLES_PER_SYNC(SPS)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sync(in_sync), .in_data(in_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int acc_exp  [NB];
  int hold_exp [NB];
  bit    pend = 0;
  int    pend_exp = 0;
  string pend_tag = "";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bin_of(input logic [DATA_W-1:0] d);
    return int'(d[DATA_W-1 -: AW]);
  endfunction

  // one cycle: check last cycle's read, drive this cycle, advance the model
  task automatic step(input bit v, input bit s, input logic [DATA_W-1:0] d,
                      input bit r, input int a, input bit w, input string tag);
    if (pend) begin
      check(mem_rd_valid === 1'b1, "R2", int'(mem_rd_valid), 1);
      check(mem_rd_data === CW'(pend_exp), pend_tag, int'(mem_rd_data), pend_exp);
    end else begin
      check(mem_rd_valid === 1'b0, "R2", int'(mem_rd_valid), 0);
    end
    in_valid    = v;
    in_sync     = s;
    in_data     = d;
    mem_rd_en   = r && !s;
    mem_rd_addr = AW'(a);
    mem_wr_en   = w;
    mem_wr_data = CW'($urandom);
    if (s) begin
      for (int i = 0; i < NB; i++) begin
        hold_exp[i] = acc_exp[i];
        acc_exp[i]  = 0;
      end
    end
    if (v) acc_exp[bin_of(d)]++;
    pend     = r && !s;
    pend_exp = hold_exp[a];
    pend_tag = tag;
    @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NB; i++) step(0, 0, '0, 1, i, 1, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) begin acc_exp[i] = 0; hold_exp[i] = 0; end
    rst_n = 1'b0; in_valid = 0; in_sync = 0; in_data = '0;
    mem_rd_en = 0; mem_rd_addr = '0; mem_wr_en = 0; mem_wr_data = '0;
    repeat (3) @(negedge clk);
    check(mem_rd_valid === 1'b0, "R2", int'(mem_rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hold page is zero before the first sync while counting goes on
    for (int i = 0; i < NB; i++) step(1, 0, DATA_W'($urandom), 1, i, 0, "R1");

    // R7: back-to-back hits on bin 3; R4: invalid samples aimed at bin 5
    for (int i = 0; i < 5; i++) step(1, 0, 8'h30 + 8'(i), 0, 0, 0, "");
    for (int i = 0; i < 4; i++) step(0, 0, 8'h51, 0, 0, 0, "");
    step(1, 0, 8'h90, 0, 0, 0, ""); step(1, 0, 8'hA0, 0, 0, 0, "");
    step(1, 0, 8'h91, 0, 0, 0, ""); step(1, 0, 8'hA1, 0, 0, 0, "");
    // R5: the sync sample (bin 7) belongs to the new interval
    step(1, 1, 8'h77, 0, 0, 0, "");
    step(0, 0, '0, 1, 3, 0, "R7");
    step(0, 0, '0, 1, 5, 0, "R4");
    step(0, 0, '0, 1, 7, 0, "R5");
    for (int i = 0; i < NB; i++) step(0, 0, '0, 1, i, 0, "R6");

    // R3: bin from the upper bits
    step(1, 0, 8'hE0, 0, 0, 0, ""); step(1, 0, 8'hEF, 0, 0, 0, "");
    step(1, 0, 8'h1F, 0, 0, 0, "");
    step(0, 1, '0, 0, 0, 0, "");
    step(0, 0, '0, 1, 14, 0, "R3");
    step(0, 0, '0, 1, 1, 0, "R3");
    step(0, 0, '0, 1, 15, 0, "R3");
    step(0, 0, '0, 1, 7, 0, "R5");

    // R9/R10: random intervals, hold page read while counting and writing
    for (int k = 0; k < 4; k++) begin
      step(1, 1, DATA_W'($urandom), 0, 0, 0, "");
      for (int j = 0; j < 50; j++) begin
        logic [DATA_W-1:0] d;
        d = DATA_W'($urandom);
        if ($urandom_range(1, 0) == 1) d[DATA_W-1] = 1'b0;
        if ($urandom_range(1, 0) == 1) d[DATA_W-2 -: AW-1] = '0;
        step($urandom_range(3, 0) != 0, 0, d, $urandom_range(1, 0) == 1,
             $urandom_range(NB - 1, 0), $urandom_range(1, 0) == 1,
             (j % 2 == 0) ? "R9" : "R10");
      end
    end

    // R11: a full interval into bin 15
    step(1, 1, 8'hF0, 0, 0, 0, "");
    for (int j = 1; j < SPS; j++) step(1, 0, 8'hF0 + 8'(j % 16), 0, 0, 0, "");
    step(0, 1, '0, 0, 0, 0, "");
    step(0, 0, '0, 1, 15, 1, "R11");
    step(0, 0, '0, 1, 0, 1, "R11");

    // R12/R8: empty interval on the stale page reads all zero
    step(0, 1, '0, 0, 0, 0, "");
    read_all("R12");
    step(1, 0, 8'hF3, 0, 0, 0, ""); step(1, 0, 8'hF4, 0, 0, 0, "");
    step(0, 1, '0, 0, 0, 0, "");
    step(0, 0, '0, 1, 15, 1, "R8");
    read_all("R8");
    step(0, 0, '0, 0, 0, 0, "");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule